// File: doc/BRIEF.md
# NAND Flash Device Command Interpreter

This block is a synthesizable model of the command side of a small NAND flash device. On each write strobe it sorts the byte on the bus into one of three kinds: a command when the command-latch input is high, an address when the address-latch input is high, and otherwise a data byte. Data bytes fill a 528-byte page register, made up of a 512-byte main area and a 16-byte spare area. A confirm command copies the register into a small array of pages during a timed busy period. During that period the ready/busy output is low.

The interpreter also enforces the device's rules. Programming can only turn bits from 1 to 0. A page accepts only a limited number of partial programs between erases. While the device is busy, only the status and reset commands are accepted. A reset command aborts the operation in progress. Reads give the host a way to observe the cells, through a column pointer that can select the first half, the second half or the spare area of a page. An erase command restores a page to all ones and clears its partial-program counters.

Top module: `nand_cmd_interp`

## Requirements
- R1: A byte written with cle=1 is a command. A byte written with ale=1 is an address: the first address byte is the column, the second is the page index (its low bits), and the third is ignored. Any other written byte is data. It goes into the page register at the current column, and the column then advances by one, stopping at 527.
- R2: Command 80h fills all 528 page-register bytes with FFh and enters load mode. Bytes that are not loaded therefore leave their cells unchanged.
- R3: Commands 00h, 01h and 50h enter read mode and set the pointer for the next column address. 00h gives column = byte. 01h gives column = 256 + byte. 50h gives column = 512 + (byte mod 16). The pointer stays in effect for a following 80h load.
- R4: Command 10h received in load mode starts programming. rb_n is low for exactly BUSY_CYCLES clock cycles.
- R5: Command 10h outside load mode is ignored: rb_n stays high and dout does not change.
- R6: While busy, 70h selects status output and FFh resets. Every other command, and every address or data byte, is dropped.
- R7: Programming stores cell AND page register, so a bit already at 0 stays at 0.
- R8: Between erases, a page accepts 2 programs that load main-area bytes and 3 that load spare-area bytes. A program that would exceed either limit changes no cell and sets the fail bit.
- R9: Status byte is {0, ready, 00000b, fail}, so it reads 40h on pass and 41h on fail. Programming and erasing switch the output to status mode. It remains there through the busy period and afterwards, until a recognised command arrives. An unrecognised code such as 23h leaves it in status mode.
- R10: Command FFh is accepted at any time. It aborts any operation without changing cells, releases rb_n on the next cycle, selects idle mode (dout = 00h) and returns the pointer to 00h.
- R11: The sequence 60h, page address byte, D0h erases the page. All its bytes become FFh, its partial-program counters are cleared, and it is busy for BUSY_CYCLES cycles. After an erase the fail bit reads 0.
- R12: In read mode dout shows the cell at the current page and column. A pulse on rd_en advances the column by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; all cells reset to FFh |
| cle | input | 1 | Marks a written byte as a command |
| ale | input | 1 | Marks a written byte as an address |
| wr_en | input | 1 | One-cycle write strobe for din |
| rd_en | input | 1 | One-cycle read strobe; advances the column in read mode |
| din | input | 8 | Bus byte: command, address or data |
| dout | output | 8 | Cell data in read mode, status byte in status mode, 00h otherwise |
| rb_n | output | 1 | Ready (1) or busy (0) |

## Verification
Most faults in this interpreter show up at the ports only after a delay. A wrong partial-program count or a lost page-register byte is invisible until the following program reports a status of 41h, or until a later read returns the wrong cell. The bench therefore drives each sequence through to a read or a status byte. A mode that changes on a dropped command shows up on dout at the very next sample, because status, read and idle output different bytes. A faulty busy counter shows up as a wrong count of low cycles on rb_n.

// File: rtl/nand_ci_pkg.sv
package nand_ci_pkg;

  typedef enum logic [2:0] {MD_IDLE, MD_LOAD, MD_READ, MD_STATUS, MD_ERASE} mode_t;
  typedef enum logic [1:0] {PT_LOW, PT_HIGH, PT_SPARE} ptr_t;

  localparam logic [7:0] OP_RD_LOW   = 8'h00;
  localparam logic [7:0] OP_RD_HIGH  = 8'h01;
  localparam logic [7:0] OP_RD_SPARE = 8'h50;
  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_PROG     = 8'h10;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_ERASE    = 8'h60;
  localparam logic [7:0] OP_ERASE_GO = 8'hD0;
  localparam logic [7:0] OP_RESET    = 8'hFF;

  // True when a program touching the given areas would pass a per-page limit.
  function automatic logic over_limit(input int unsigned used_m, input int unsigned used_s,
                                      input int unsigned lim_m, input int unsigned lim_s,
                                      input logic hit_m, input logic hit_s);
    return (hit_m && used_m >= lim_m) || (hit_s && used_s >= lim_s);
  endfunction

  function automatic logic [7:0] status_byte(input logic ready, input logic failed);
    return {1'b0, ready, 5'b00000, failed};
  endfunction

  // Column step that saturates at the last byte of the page.
  function automatic int unsigned next_col(input int unsigned col, input int unsigned last);
    return (col >= last) ? col : col + 1;
  endfunction

endpackage

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter  int MAIN_BYTES  = 512,
  parameter  int SPARE_BYTES = 16,
  localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES,
  localparam int COL_W       = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic             wr,
  input  logic [COL_W-1:0] wcol,
  input  logic [7:0]       wdata,
  output logic [7:0]       bytes_o [PAGE_BYTES],
  output logic             hit_main,
  output logic             hit_spare
);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < PAGE_BYTES; b++) bytes_o[b] <= 8'hFF;
      hit_main  <= 1'b0;
      hit_spare <= 1'b0;
    end else if (preset) begin
      for (int b = 0; b < PAGE_BYTES; b++) bytes_o[b] <= 8'hFF;
      hit_main  <= 1'b0;
      hit_spare <= 1'b0;
    end else if (wr) begin
      bytes_o[wcol] <= wdata;
      if (wcol < SPARE_BASE) hit_main <= 1'b1;
      else                   hit_spare <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array import nand_ci_pkg::*; #(
  parameter  int PAGES       = 4,
  parameter  int MAIN_BYTES  = 512,
  parameter  int SPARE_BYTES = 16,
  parameter  int MAIN_LIMIT  = 2,
  parameter  int SPARE_LIMIT = 3,
  localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES,
  localparam int COL_W       = $clog2(PAGE_BYTES),
  localparam int PG_W        = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CNT_W       = $clog2(((MAIN_LIMIT > SPARE_LIMIT) ? MAIN_LIMIT : SPARE_LIMIT) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog,
  input  logic             erase,
  input  logic [PG_W-1:0]  page,
  input  logic [COL_W-1:0] col,
  input  logic [7:0]       load_bytes [PAGE_BYTES],
  input  logic             hit_main,
  input  logic             hit_spare,
  output logic [7:0]       rd_data,
  output logic             limit_hit
);
  logic [7:0]       cells  [PAGES][PAGE_BYTES];
  logic [CNT_W-1:0] used_m [PAGES];
  logic [CNT_W-1:0] used_s [PAGES];

  assign rd_data   = cells[page][col];
  assign limit_hit = over_limit(32'(used_m[page]), 32'(used_s[page]),
                                MAIN_LIMIT, SPARE_LIMIT, hit_main, hit_spare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) begin
        for (int b = 0; b < PAGE_BYTES; b++) cells[p][b] <= 8'hFF;
        used_m[p] <= '0;
        used_s[p] <= '0;
      end
    end else if (erase) begin
      for (int b = 0; b < PAGE_BYTES; b++) cells[page][b] <= 8'hFF;
      used_m[page] <= '0;
      used_s[page] <= '0;
    end else if (prog) begin
      for (int b = 0; b < PAGE_BYTES; b++) cells[page][b] <= cells[page][b] & load_bytes[b];
      if (hit_main)  used_m[page] <= used_m[page] + 1'b1;
      if (hit_spare) used_s[page] <= used_s[page] + 1'b1;
    end
  end
endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl import nand_ci_pkg::*; #(
  parameter  int MAIN_BYTES  = 512,
  parameter  int SPARE_BYTES = 16,
  parameter  int PAGES       = 4,
  parameter  int BUSY_CYCLES = 20,
  localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES,
  localparam int COL_W       = $clog2(PAGE_BYTES),
  localparam int PG_W        = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       din,
  input  logic             limit_hit,
  output mode_t            mode,
  output logic             busy,
  output logic             fail,
  output logic             prog_go,
  output logic             op_done,
  output logic             op_erase,
  output logic             preset,
  output logic             buf_wr,
  output logic [COL_W-1:0] col,
  output logic [PG_W-1:0]  page
);
  localparam int BW   = $clog2(BUSY_CYCLES + 1);
  localparam int SP_W = $clog2(SPARE_BYTES);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);
  localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(MAIN_BYTES / 2);

  logic          cmd_stb, addr_stb, data_stb, is_reset, erase_go, step_col;
  ptr_t          ptr;
  logic [1:0]    aidx;
  logic [BW-1:0] left;

  function automatic logic [COL_W-1:0] addr_col(input ptr_t p, input logic [7:0] a);
    case (p)
      PT_SPARE: return SPARE_BASE + COL_W'(a[SP_W-1:0]);
      PT_HIGH:  return HALF_BASE + COL_W'(a);
      default:  return COL_W'(a);
    endcase
  endfunction

  assign cmd_stb  = wr_en & cle;
  assign addr_stb = wr_en & ale & ~cle;
  assign data_stb = wr_en & ~cle & ~ale;
  assign is_reset = cmd_stb && (din == OP_RESET);
  assign prog_go  = cmd_stb && !busy && (din == OP_PROG) && (mode == MD_LOAD);
  assign erase_go = cmd_stb && !busy && (din == OP_ERASE_GO) && (mode == MD_ERASE);
  assign op_done  = busy && (left == BW'(1)) && !is_reset;
  assign preset   = cmd_stb && !busy && (din == OP_LOAD);
  assign buf_wr   = data_stb && !busy && (mode == MD_LOAD);
  assign step_col = buf_wr || (rd_en && !wr_en && !busy && (mode == MD_READ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MD_IDLE;
      busy     <= 1'b0;
      left     <= '0;
      op_erase <= 1'b0;
      ptr      <= PT_LOW;
      col      <= '0;
      page     <= '0;
      aidx     <= '0;
      fail     <= 1'b0;
    end else begin
      if (op_done) begin
        busy <= 1'b0;
        fail <= !op_erase && limit_hit;
      end else if (busy) begin
        left <= left - 1'b1;
      end

      if (is_reset) begin
        mode <= MD_IDLE;
        busy <= 1'b0;
        ptr  <= PT_LOW;
        aidx <= '0;
      end else if (cmd_stb && busy) begin
        if (din == OP_STATUS) mode <= MD_STATUS;
      end else if (cmd_stb) begin
        case (din)
          OP_RD_LOW:   begin ptr <= PT_LOW;   mode <= MD_READ; aidx <= '0; end
          OP_RD_HIGH:  begin ptr <= PT_HIGH;  mode <= MD_READ; aidx <= '0; end
          OP_RD_SPARE: begin ptr <= PT_SPARE; mode <= MD_READ; aidx <= '0; end
          OP_LOAD:     begin mode <= MD_LOAD;  aidx <= '0; end
          OP_ERASE:    begin mode <= MD_ERASE; aidx <= '0; end
          OP_STATUS:   mode <= MD_STATUS;
          OP_PROG, OP_ERASE_GO: begin
            if (prog_go || erase_go) begin
              busy     <= 1'b1;
              left     <= BW'(BUSY_CYCLES);
              op_erase <= erase_go;
              mode     <= MD_STATUS;
            end
          end
          default: ;
        endcase
      end else if (addr_stb && !busy) begin
        if (mode == MD_ERASE) begin
          if (aidx == 2'd0) page <= din[PG_W-1:0];
        end else if (mode == MD_LOAD || mode == MD_READ) begin
          if (aidx == 2'd0)      col  <= addr_col(ptr, din);
          else if (aidx == 2'd1) page <= din[PG_W-1:0];
        end
        if (aidx != 2'd3) aidx <= aidx + 2'd1;
      end else if (step_col) begin
        col <= COL_W'(next_col(32'(col), PAGE_BYTES - 1));
      end
    end
  end
endmodule

// File: rtl/nand_cmd_interp.sv
module nand_cmd_interp import nand_ci_pkg::*; #(
  parameter int PAGES       = 4,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int BUSY_CYCLES = 20,
  parameter int MAIN_LIMIT  = 2,
  parameter int SPARE_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       rb_n
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int PG_W       = (PAGES > 1) ? $clog2(PAGES) : 1;

  mode_t            mode;
  logic             busy, fail, prog_go, op_done, op_erase, preset, buf_wr;
  logic             hit_main, hit_spare, limit_hit, cmd_stb;
  logic             commit_prog, commit_erase;
  logic [COL_W-1:0] col;
  logic [PG_W-1:0]  page;
  logic [7:0]       page_reg [PAGE_BYTES];
  logic [7:0]       cell_rd;

  assign cmd_stb      = wr_en & cle;
  assign commit_prog  = op_done && !op_erase && !limit_hit;
  assign commit_erase = op_done && op_erase;

  nand_cmd_ctrl #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
                  .PAGES(PAGES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .limit_hit(limit_hit), .mode(mode), .busy(busy), .fail(fail),
    .prog_go(prog_go), .op_done(op_done), .op_erase(op_erase), .preset(preset),
    .buf_wr(buf_wr), .col(col), .page(page)
  );

  nand_page_buf #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .preset(preset), .wr(buf_wr), .wcol(col), .wdata(din),
    .bytes_o(page_reg), .hit_main(hit_main), .hit_spare(hit_spare)
  );

  nand_cell_array #(.PAGES(PAGES), .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
                    .MAIN_LIMIT(MAIN_LIMIT), .SPARE_LIMIT(SPARE_LIMIT)) u_array (
    .clk(clk), .rst_n(rst_n), .prog(commit_prog), .erase(commit_erase), .page(page),
    .col(col), .load_bytes(page_reg), .hit_main(hit_main), .hit_spare(hit_spare),
    .rd_data(cell_rd), .limit_hit(limit_hit)
  );

  assign rb_n = ~busy;

  always_comb begin
    case (mode)
      MD_STATUS: dout = status_byte(~busy, fail);
      MD_READ:   dout = cell_rd;
      default:   dout = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_cmd_interp_chk.sv
module nand_cmd_interp_chk import nand_ci_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_stb,
  input logic [7:0] din,
  input mode_t      mode,
  input logic       busy,
  input logic       rb_n,
  input logic [7:0] dout,
  input logic       op_done,
  input logic       op_erase,
  input logic       limit_hit,
  input logic       fail,
  input logic       prog_go
);
  assert_prog_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> !rb_n);

  assert_bare_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && din == OP_PROG && rb_n && mode != MD_LOAD) |=> (rb_n && $stable(mode)));

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_stb && din != OP_STATUS && din != OP_RESET) |=> $stable(mode));

  assert_limit_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_erase && limit_hit) |=> fail);

  assert_status_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STATUS) |-> (dout[6] == rb_n && dout[0] == fail && dout[5:1] == 5'b0));

  assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && din == OP_RESET) |=> (rb_n && mode == MD_IDLE && dout == 8'h00));

  assert_erase_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_erase) |=> !fail);

  assert_busy_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_n) |-> $past(prog_go || (cmd_stb && din == OP_ERASE_GO)));
endmodule

bind nand_cmd_interp nand_cmd_interp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .din(din), .mode(mode), .busy(busy),
  .rb_n(rb_n), .dout(dout), .op_done(op_done), .op_erase(op_erase),
  .limit_hit(limit_hit), .fail(fail), .prog_go(prog_go)
);

// File: tb/nand_cmd_interp_test.sv
`timescale 1ns/1ps
module nand_cmd_interp_test;
  localparam int BUSY = 20;
  localparam logic [2:0] VC = 3'd0, VA = 3'd1, VD = 3'd2, VR = 3'd3, VW = 3'd4, VS = 3'd5;
  localparam int NV = 61;

  // {op, requirement, byte}: VR/VS compare dout with byte, VW counts busy cycles
  localparam logic [14:0] VECS [NV] = '{
    // R1 R2: load two main bytes at page 1 column 5, program, status, R9 stays in status
    {VC,4'd1,8'h80},{VA,4'd1,8'h05},{VA,4'd1,8'h01},{VA,4'd1,8'h00},
    {VD,4'd1,8'hA5},{VD,4'd1,8'h3C},{VC,4'd4,8'h10},{VW,4'd4,8'h00},
    {VS,4'd9,8'h40},{VC,4'd9,8'h23},{VS,4'd9,8'h40},
    // R12 R2: read back page 1 from column 4
    {VC,4'd12,8'h00},{VA,4'd12,8'h04},{VA,4'd12,8'h01},{VA,4'd12,8'h00},
    {VR,4'd2,8'hFF},{VR,4'd12,8'hA5},{VR,4'd12,8'h3C},{VR,4'd2,8'hFF},
    // R7: second main program at column 5 ANDs into the cell
    {VC,4'd7,8'h80},{VA,4'd7,8'h05},{VA,4'd7,8'h01},{VA,4'd7,8'h00},
    {VD,4'd7,8'h0F},{VC,4'd7,8'h10},{VW,4'd4,8'h00},{VS,4'd9,8'h40},
    {VC,4'd7,8'h00},{VA,4'd7,8'h05},{VA,4'd7,8'h01},{VA,4'd7,8'h00},
    {VR,4'd7,8'h05},{VR,4'd7,8'h3C},
    // R3: spare pointer, column 512+2 of page 1
    {VC,4'd3,8'h50},{VC,4'd3,8'h80},{VA,4'd3,8'h02},{VA,4'd3,8'h01},
    {VA,4'd3,8'h00},{VD,4'd3,8'h12},{VC,4'd3,8'h10},{VW,4'd4,8'h00},
    {VS,4'd3,8'h40},{VC,4'd3,8'h50},{VA,4'd3,8'h02},{VA,4'd3,8'h01},
    {VA,4'd3,8'h00},{VR,4'd3,8'h12},
    // R8: third main program on page 1 fails and leaves the cells alone
    {VC,4'd8,8'h00},{VC,4'd8,8'h80},{VA,4'd8,8'h00},{VA,4'd8,8'h01},
    {VA,4'd8,8'h00},{VD,4'd8,8'h00},{VC,4'd8,8'h10},{VW,4'd4,8'h00},
    {VS,4'd8,8'h41},{VC,4'd8,8'h00},{VA,4'd8,8'h00},{VA,4'd8,8'h01},
    {VA,4'd8,8'h00},{VR,4'd8,8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0, cle = 1'b0, ale = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       rb_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  nand_cmd_interp #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .wr_en(wr_en), .rd_en(rd_en),
    .din(din), .dout(dout), .rb_n(rb_n)
  );

  task automatic check(input int req, input int got, input int exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk);
    cle = c; ale = a; din = v; wr_en = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_busy(input int req);
    int n = 0;
    while (rb_n === 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(req, n, BUSY, "busy cycle count");
  endtask

  task automatic read_at(input logic [7:0] ptr, input logic [7:0] col, input logic [7:0] pg);
    bus(1, 0, ptr); bus(0, 1, col); bus(0, 1, pg); bus(0, 1, 8'h00);
  endtask

  task automatic load_prog(input logic [7:0] ptr, input logic [7:0] col, input logic [7:0] pg,
                           input logic [7:0] val);
    bus(1, 0, ptr); bus(1, 0, 8'h80);
    bus(0, 1, col); bus(0, 1, pg); bus(0, 1, 8'h00);
    bus(0, 0, val); bus(1, 0, 8'h10);
    wait_busy(4);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R4 watchdog expired: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state is ready and idle
    check(10, int'(rb_n), 1, "rb_n after reset");
    check(10, dout, 8'h00, "dout idle after reset");
    // R5: bare confirm in idle does nothing
    bus(1, 0, 8'h10);
    check(5, int'(rb_n), 1, "rb_n after bare 10h");
    check(5, dout, 8'h00, "dout after bare 10h");
    repeat (3) @(negedge clk);
    check(5, int'(rb_n), 1, "rb_n later after bare 10h");

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [3:0] rq;
      logic [7:0] v;
      {op, rq, v} = VECS[i];
      case (op)
        VC: bus(1, 0, v);
        VA: bus(0, 1, v);
        VD: bus(0, 0, v);
        VR: begin check(int'(rq), dout, v, "read byte"); rd_pulse(); end
        VW: wait_busy(int'(rq));
        default: check(int'(rq), dout, v, "status byte");
      endcase
    end

    // R5: bare confirm in read mode keeps showing the cell
    read_at(8'h00, 8'h05, 8'h01);
    bus(1, 0, 8'h10);
    check(5, dout, 8'h05, "read mode after bare 10h");
    check(5, int'(rb_n), 1, "rb_n after bare 10h in read");

    // R3: second-half pointer lands at column 256+3
    load_prog(8'h01, 8'h03, 8'h00, 8'h5A);
    check(3, dout, 8'h40, "status after half-pointer program");
    read_at(8'h01, 8'h03, 8'h00);
    check(3, dout, 8'h5A, "second half column 259");
    read_at(8'h00, 8'h03, 8'h00);
    check(3, dout, 8'hFF, "first half column 3 untouched");

    // R6: commands and data during busy are dropped
    bus(1, 0, 8'h00); bus(1, 0, 8'h80);
    bus(0, 1, 8'h00); bus(0, 1, 8'h02); bus(0, 1, 8'h00);
    bus(0, 0, 8'h11); bus(1, 0, 8'h10);
    bus(1, 0, 8'h00);
    check(6, dout, 8'h00, "status while busy after dropped 00h");
    check(6, int'(rb_n), 0, "still busy after dropped 00h");
    bus(0, 0, 8'h22);
    bus(1, 0, 8'h70);
    check(6, dout, 8'h00, "status accepted while busy");
    while (rb_n !== 1'b1) @(negedge clk);
    check(6, dout, 8'h40, "status after busy drop test");
    read_at(8'h00, 8'h00, 8'h02);
    check(6, dout, 8'h11, "loaded byte committed");
    rd_pulse();
    check(6, dout, 8'hFF, "dropped data not committed");

    // R10: reset aborts a program without touching cells
    bus(1, 0, 8'h00); bus(1, 0, 8'h80);
    bus(0, 1, 8'h00); bus(0, 1, 8'h03); bus(0, 1, 8'h00);
    bus(0, 0, 8'h00); bus(1, 0, 8'h10);
    bus(1, 0, 8'hFF);
    check(10, int'(rb_n), 1, "rb_n released by reset");
    check(10, dout, 8'h00, "idle after reset command");
    repeat (BUSY + 10) @(negedge clk);
    check(10, int'(rb_n), 1, "rb_n stays high after abort");
    read_at(8'h00, 8'h00, 8'h03);
    check(10, dout, 8'hFF, "aborted program left cell");
    // R10: reset returns the pointer to the low main half
    bus(1, 0, 8'h50); bus(1, 0, 8'hFF); bus(1, 0, 8'h80);
    bus(0, 1, 8'h00); bus(0, 1, 8'h03); bus(0, 1, 8'h00);
    bus(0, 0, 8'h77); bus(1, 0, 8'h10);
    wait_busy(4);
    check(10, dout, 8'h40, "status after pointer test");
    read_at(8'h00, 8'h00, 8'h03);
    check(10, dout, 8'h77, "load went to main column 0");

    // R11: erase restores page 1 and clears its counters
    bus(1, 0, 8'h60); bus(0, 1, 8'h01); bus(1, 0, 8'hD0);
    wait_busy(11);
    check(11, dout, 8'h40, "status after erase");
    read_at(8'h00, 8'h05, 8'h01);
    check(11, dout, 8'hFF, "erased cell");
    load_prog(8'h00, 8'h05, 8'h01, 8'h33);
    check(11, dout, 8'h40, "first main program after erase");
    load_prog(8'h00, 8'h06, 8'h01, 8'h44);
    check(11, dout, 8'h40, "second main program after erase");

    // R8: spare limit of three programs per page
    for (int k = 0; k < 4; k++) begin
      load_prog(8'h50, 8'(k), 8'h01, 8'h00);
      check(8, dout, (k < 3) ? 8'h40 : 8'h41, "spare program status");
    end
    read_at(8'h50, 8'h03, 8'h01);
    check(8, dout, 8'hFF, "rejected spare program left cell");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule